// File: doc/BRIEF.md
# SPI Slave Pause Gate

This block is the front-end gate for an SPI memory slave. It samples the serial pins (chip select, serial clock, serial data in and the active-low pause request) in a fast system clock. From those samples it decides when the slave's command shifter may advance. The gate gives the shifter three things: a level that says shifting is allowed, a one-cycle strobe for each qualified rising edge of the serial clock, and the synchronised data bit. It also drives the output-enable of the serial data output.

A pause requested by the master takes effect only while the serial clock is low. If the request changes while the clock is high, the change is held back until the clock next goes low. While paused, the output is released to high impedance and clock and data activity is ignored, so the shifter keeps its bits and bit count. If chip select is released during a pause, the gate emits a one-cycle internal reset pulse and enters a lockout. The lockout clears only once the pause request is released while the slave is deselected, so a later selection starts cleanly and cannot fall straight back into a pause.

Top module: `serial_pause_gate`

## Requirements
- R1: After reset, shift_ok, clk_rise_stb, so_oe and logic_rst are all 0.
- R2: While selected and not paused, each rising edge of sck_pin gives exactly one clk_rise_stb pulse of one cycle, and si_bit follows si_pin. Each output follows its pin within 3 system clock cycles.
- R3: If hold_n_pin falls while sck_pin is high, shift_ok and so_oe stay 1 until sck_pin goes low, and then fall.
- R4: If hold_n_pin rises while sck_pin is high during a pause, the pause continues until sck_pin goes low, and that low does not produce a clk_rise_stb.
- R5: While paused, so_oe is 0, shift_ok is 0, and sck_pin toggles produce no clk_rise_stb.
- R6: A hold_n_pin change while sck_pin is already low takes effect within 3 system clock cycles.
- R7: cs_n_pin rising during a pause produces exactly one logic_rst pulse, one cycle wide.
- R8: After that reset, selecting again with hold_n_pin still low leaves shift_ok at 0 and produces no strobes. Normal operation returns only after hold_n_pin is high while cs_n_pin is high, followed by cs_n_pin going low.
- R9: hold_n_pin has no effect while cs_n_pin is high: a later selection with hold_n_pin high is active at once and produces no logic_rst.
- R10: cs_n_pin rising outside a pause makes shift_ok and so_oe 0 and produces no logic_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data in pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| si_bit | output | 1 | Synchronised serial data bit |
| shift_ok | output | 1 | Shifter may advance (selected, not paused) |
| clk_rise_stb | output | 1 | One-cycle strobe per qualified serial clock rise |
| so_oe | output | 1 | Output enable for the serial data output |
| logic_rst | output | 1 | One-cycle reset pulse for the command logic |

## Verification
A wrong pause state shows at the ports within three system cycles: shift_ok and so_oe take the wrong level, or the strobe count changes across a window where serial clock pulses should be ignored. A pause entered while the clock is high would drop shift_ok before the clock falls, so a sample taken while the clock is held high catches it. A broken lockout shows as strobes, or shift_ok high, after reselection with the pause request still low. A misplaced reset pulse shows as a logic_rst count other than one after deselection during a pause, or other than zero after any other deselection.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PAUSED = 2'd2,
        ST_LOCKED = 2'd3
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        sck_prev;
        logic        stb;
        logic        rst_pulse;
    } gate_regs_t;

    localparam int PIN_COUNT = 4;
    localparam int PIN_CS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_SI    = 2;
    localparam int PIN_HOLD  = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int                WIDTH  = 4,
    parameter int                STAGES = 2,
    parameter logic [WIDTH-1:0]  INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = pins_in;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= INIT;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign pins_out = stage_q[STAGES-1];
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import pause_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic shift_ok,
    output logic clk_rise_stb,
    output logic so_oe,
    output logic logic_rst
);
    gate_regs_t r_q, r_d;

    always_comb begin
        r_d           = r_q;
        r_d.sck_prev  = sck_s;
        r_d.stb       = 1'b0;
        r_d.rst_pulse = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!cs_n_s) r_d.state = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cs_n_s) begin
                    r_d.state = ST_IDLE;
                end else if (!hold_n_s && !sck_s) begin
                    r_d.state = ST_PAUSED;
                end else begin
                    r_d.stb = sck_s && !r_q.sck_prev;
                end
            end
            ST_PAUSED: begin
                if (cs_n_s) begin
                    r_d.state     = ST_LOCKED;
                    r_d.rst_pulse = 1'b1;
                end else if (hold_n_s && !sck_s) begin
                    r_d.state = ST_ACTIVE;
                end
            end
            ST_LOCKED: begin
                if (cs_n_s && hold_n_s) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.sck_prev  <= 1'b0;
            r_q.stb       <= 1'b0;
            r_q.rst_pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shift_ok     = (r_q.state == ST_ACTIVE);
    assign so_oe        = (r_q.state == ST_ACTIVE);
    assign clk_rise_stb = r_q.stb;
    assign logic_rst    = r_q.rst_pulse;

    assert_pause_on_sck_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_ACTIVE && r_q.state == ST_PAUSED) |-> !$past(sck_s));

    assert_resume_on_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_PAUSED && r_q.state == ST_ACTIVE) |-> !$past(sck_s));

    assert_strobe_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stb |-> $past(r_q.state) == ST_ACTIVE);

    assert_reset_enters_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rst_pulse |-> (r_q.state == ST_LOCKED && $past(r_q.state) == ST_PAUSED));

    assert_lock_exits_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_LOCKED && r_q.state != ST_LOCKED) |-> (r_q.state == ST_IDLE && $past(hold_n_s)));

    assert_plain_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_ACTIVE && r_q.state == ST_IDLE) |-> !r_q.rst_pulse);
endmodule

// File: rtl/serial_pause_gate.sv
module serial_pause_gate
    import pause_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic si_pin,
    input  logic hold_n_pin,
    output logic si_bit,
    output logic shift_ok,
    output logic clk_rise_stb,
    output logic so_oe,
    output logic logic_rst
);
    localparam logic [PIN_COUNT-1:0] IDLE_PINS = PIN_COUNT'(4'b1001);

    logic [PIN_COUNT-1:0] raw_pins;
    logic [PIN_COUNT-1:0] sync_pins;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_CS]   = cs_n_pin;
        raw_pins[PIN_SCK]  = sck_pin;
        raw_pins[PIN_SI]   = si_pin;
        raw_pins[PIN_HOLD] = hold_n_pin;
    end

    pin_sync #(
        .WIDTH (PIN_COUNT),
        .STAGES(SYNC_STAGES),
        .INIT  (IDLE_PINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (raw_pins),
        .pins_out(sync_pins)
    );

    pause_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (sync_pins[PIN_CS]),
        .sck_s       (sync_pins[PIN_SCK]),
        .hold_n_s    (sync_pins[PIN_HOLD]),
        .shift_ok    (shift_ok),
        .clk_rise_stb(clk_rise_stb),
        .so_oe       (so_oe),
        .logic_rst   (logic_rst)
    );

    assign si_bit = sync_pins[PIN_SI];
endmodule

// File: tb/sim_serial_pause_gate.sv
module sim_serial_pause_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1;
    logic si_bit, shift_ok, clk_rise_stb, so_oe, logic_rst;

    int total = 0, bad = 0;
    int n_stb = 0, n_rst = 0;

    always #4 clk = ~clk;

    serial_pause_gate u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .si_pin(si_pin), .hold_n_pin(hold_n_pin), .si_bit(si_bit),
        .shift_ok(shift_ok), .clk_rise_stb(clk_rise_stb), .so_oe(so_oe),
        .logic_rst(logic_rst)
    );

    always @(posedge clk) begin
        if (clk_rise_stb) n_stb++;
        if (logic_rst) n_rst++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sck(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sck_pin = 1'b1;
            repeat (4) @(posedge clk);
            @(negedge clk) sck_pin = 1'b0;
            repeat (4) @(posedge clk);
        end
        settle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!shift_ok && !so_oe && !logic_rst && !clk_rise_stb, "R1 reset outputs",
            {shift_ok, so_oe, logic_rst, clk_rise_stb}, 0);
    endtask

    task automatic t_shift();
        int s0;
        cs_n_pin = 1'b0; si_pin = 1'b1;
        settle();
        chk(shift_ok && so_oe, "R2 active after select", shift_ok, 1);
        chk(si_bit == 1'b1, "R2 si follows", si_bit, 1);
        s0 = n_stb;
        pulse_sck(3);
        chk(n_stb - s0 == 3, "R2 strobe count", n_stb - s0, 3);
    endtask

    task automatic t_hold_sck_high();
        int s0 = n_stb;
        @(negedge clk) sck_pin = 1'b1;
        settle();
        hold_n_pin = 1'b0;
        settle();
        chk(shift_ok && so_oe, "R3 pause deferred while sck high", shift_ok, 1);
        sck_pin = 1'b0;
        settle();
        chk(!shift_ok && !so_oe, "R3 paused after sck low", so_oe, 0);
        chk(n_stb - s0 == 1, "R3 only the pre-pause rise counted", n_stb - s0, 1);
    endtask

    task automatic t_pause_ignores();
        int s0 = n_stb;
        si_pin = 1'b0;
        pulse_sck(4);
        chk(n_stb == s0, "R5 no strobes while paused", n_stb - s0, 0);
        chk(!so_oe && !shift_ok, "R5 output released while paused", so_oe, 0);
    endtask

    task automatic t_release_sck_high();
        int s0 = n_stb;
        sck_pin = 1'b1;
        settle();
        hold_n_pin = 1'b1;
        settle();
        chk(!shift_ok, "R4 pause held while sck high", shift_ok, 0);
        sck_pin = 1'b0;
        settle();
        chk(shift_ok && so_oe, "R4 resumed after sck low", shift_ok, 1);
        chk(n_stb == s0, "R4 no strobe across resume", n_stb - s0, 0);
    endtask

    task automatic t_hold_sck_low();
        hold_n_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!shift_ok, "R6 immediate pause with sck low", shift_ok, 0);
        hold_n_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(shift_ok, "R6 immediate resume with sck low", shift_ok, 1);
    endtask

    task automatic t_deselect_in_pause();
        int r0, s0;
        hold_n_pin = 1'b0;
        settle();
        r0 = n_rst;
        cs_n_pin = 1'b1;
        settle();
        chk(n_rst - r0 == 1, "R7 single reset pulse", n_rst - r0, 1);
        chk(!logic_rst, "R7 pulse one cycle", logic_rst, 0);
        cs_n_pin = 1'b0;
        settle();
        s0 = n_stb;
        pulse_sck(2);
        chk(!shift_ok && n_stb == s0, "R8 locked with hold low", n_stb - s0, 0);
        hold_n_pin = 1'b1;
        settle();
        chk(!shift_ok, "R8 still locked while selected", shift_ok, 0);
        cs_n_pin = 1'b1;
        settle();
        cs_n_pin = 1'b0;
        settle();
        chk(shift_ok && so_oe, "R8 fresh select resumes", shift_ok, 1);
        s0 = n_stb;
        pulse_sck(1);
        chk(n_stb - s0 == 1, "R8 strobes after restart", n_stb - s0, 1);
    endtask

    task automatic t_hold_while_deselected();
        int r0 = n_rst;
        cs_n_pin = 1'b1;
        settle();
        chk(!shift_ok && !so_oe && n_rst == r0, "R10 plain deselect", n_rst - r0, 0);
        hold_n_pin = 1'b0;
        settle();
        hold_n_pin = 1'b1;
        settle();
        cs_n_pin = 1'b0;
        settle();
        chk(shift_ok && n_rst == r0, "R9 hold ignored when deselected", shift_ok, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        settle();
        t_shift();
        t_hold_sck_high();
        t_pause_ignores();
        t_release_sck_high();
        t_hold_sck_low();
        t_deselect_in_pause();
        t_hold_while_deselected();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule